// File: doc/BRIEF.md
# Receive Byte Buffer with Threshold Flags

This block sits between a serial receiver and whatever consumes received characters. Each byte comes with a small tag of line-error bits. The block stores up to sixteen entries in arrival order and hands them out through a pop interface. The byte and tag of the entry taken by a pop appear on the read outputs one cycle later and stay there until the next accepted pop.

Two threshold comparators watch the fill count. Each one takes a 2-bit code that selects a level of 1, 4, 8 or 14 entries.
- The first comparator raises a data-available flag once the count is at or above its level.
- The second comparator drives a flow-control request line. The line asks the far end to keep sending while the count is below the second level, and withdraws the request once that level is reached. One input selects whether the request line is active-high or active-low.

Status outputs give empty, full, the fill count and a sticky overflow flag. A synchronous flush input discards all stored entries.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `count`=0, `overflow`=0, and `rd_data` and `rd_err` are 0.
- R2: Entries are popped in the order they were pushed. The data and tag of an accepted pop appear on `rd_data`/`rd_err` in the cycle after the pop and hold until the next accepted pop.
- R3: `count` equals the number of stored entries (0 to 16). `empty` is 1 exactly when the count is 0, and `full` is 1 exactly when the count is 16.
- R4: `data_avail` is 1 exactly when `count` is at least the level selected by `avail_sel`, where code 0 selects 1, code 1 selects 4, code 2 selects 8 and code 3 selects 14.
- R5: The flow-control request is asserted while `count` is below the level selected by `rts_sel` (same code map as R4), and deasserted otherwise. `rts_sel` is independent of `avail_sel`.
- R6: With `rts_active_low`=0, an asserted request drives `rts_out`=1. With `rts_active_low`=1, an asserted request drives `rts_out`=0.
- R7: A push while full stores nothing and leaves the count unchanged. It also sets `overflow`, which stays set.
- R8: `ovf_clr` clears `overflow` in the next cycle. If a dropped push happens in the same cycle, `overflow` stays set.
- R9: A pop while empty leaves `count`, `rd_data` and `rd_err` unchanged.
- R10: `flush` makes the buffer empty in the next cycle. It overrides a push and a pop in the same cycle, and it leaves `rd_data` unchanged.
- R11: A push and a pop in the same cycle, when the buffer is neither empty nor full, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push request from the receiver |
| wr_data | input | 8 | Received byte |
| wr_err | input | 3 | Line-error tag stored with the byte |
| rd_en | input | 1 | Pop request |
| rd_data | output | 8 | Byte of the last accepted pop |
| rd_err | output | 3 | Tag of the last accepted pop |
| flush | input | 1 | Synchronous discard of all entries |
| ovf_clr | input | 1 | Clears the overflow flag |
| avail_sel | input | 2 | Data-available level code |
| rts_sel | input | 2 | Flow-control level code |
| rts_active_low | input | 1 | 1 makes the request line active-low |
| empty | output | 1 | No entries stored |
| full | output | 1 | Sixteen entries stored |
| count | output | 5 | Fill count |
| overflow | output | 1 | Sticky dropped-push flag |
| data_avail | output | 1 | Count is at or above the data-available level |
| rts_out | output | 1 | Flow-control request line |

## Verification
The assertions check a set of cycle-level properties at every clock:
- the count never exceeds the depth, and a flush always empties the buffer;
- a push while full never raises the count and always sets the overflow flag, and that flag persists until it is cleared;
- a pop while empty leaves the read outputs unchanged;
- at the two extremes of fill, the data-available flag and the request line take their fixed values.

Only the bench's scenarios can show the rest: FIFO ordering of data and tags, the exact level for each of the four threshold codes at every fill level, both request polarities, and the relative priority of flush, clear and simultaneous push/pop.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;

    localparam int LVL_C0 = 1;
    localparam int LVL_C1 = 4;
    localparam int LVL_C2 = 8;
    localparam int LVL_C3 = 14;

    typedef logic [1:0] trig_code_t;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_entry_t     push_entry,
    input  logic          pop,
    input  logic          flush,
    output rx_entry_t     out_entry,
    output logic [CW-1:0] fill,
    output logic          is_empty,
    output logic          is_full,
    output logic          push_dropped
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
        rx_entry_t     head;
    } store_st_t;

    store_st_t st_d, st_q;
    rx_entry_t mem_q [DEPTH];
    logic      do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH)) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            if (do_push) begin
                st_d.wr_ptr = ptr_next(st_q.wr_ptr);
            end
            if (do_pop) begin
                st_d.rd_ptr = ptr_next(st_q.rd_ptr);
                st_d.head   = mem_q[st_q.rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr_ptr] <= push_entry;
        end
    end

    assign out_entry    = st_q.head;
    assign fill         = st_q.cnt;
    assign is_empty     = (st_q.cnt == '0);
    assign is_full      = (st_q.cnt == CW'(DEPTH));
    assign push_dropped = push && is_full && !flush;

    // R3: fill never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R7: a push that finds the buffer full never raises the fill
    p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !flush) |=> (fill <= $past(fill)));

    // R10: flush empties the buffer in one cycle
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> is_empty);

    // R9: a pop on an empty buffer leaves the read value alone
    p_pop_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty) |=> $stable(out_entry));
endmodule

// File: rtl/rxf_thresh.sv
module rxf_thresh
    import rxf_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [CW-1:0] fill,
    input  trig_code_t    code,
    output logic          reached
);
    logic [CW-1:0] level;

    always_comb begin
        case (code)
            2'd0:    level = CW'(LVL_C0);
            2'd1:    level = CW'(LVL_C1);
            2'd2:    level = CW'(LVL_C2);
            default: level = CW'(LVL_C3);
        endcase
    end

    assign reached = (fill >= level);
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic drop_evt,
    input  logic clr,
    output logic sticky
);
    typedef struct packed {
        logic ovf;
    } flag_st_t;

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr) begin
            fl_d.ovf = 1'b0;
        end
        if (drop_evt) begin
            fl_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign sticky = fl_q.ovf;

    // R7: a dropped push always leaves the flag set
    p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> sticky);

    // R8: without a clear, the flag persists
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> sticky);
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    input  logic              flush,
    input  logic              ovf_clr,
    input  logic [1:0]        avail_sel,
    input  logic [1:0]        rts_sel,
    input  logic              rts_active_low,
    output logic              empty,
    output logic              full,
    output logic [CW-1:0]     count,
    output logic              overflow,
    output logic              data_avail,
    output logic              rts_out
);
    rx_entry_t in_entry, head_entry;
    logic      dropped;
    logic      rts_level_hit;
    logic      rts_request;

    assign in_entry.data = wr_data;
    assign in_entry.err  = wr_err;

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (wr_en),
        .push_entry   (in_entry),
        .pop          (rd_en),
        .flush        (flush),
        .out_entry    (head_entry),
        .fill         (count),
        .is_empty     (empty),
        .is_full      (full),
        .push_dropped (dropped)
    );

    rxf_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .drop_evt (dropped),
        .clr      (ovf_clr),
        .sticky   (overflow)
    );

    rxf_thresh #(.CW(CW)) u_avail_cmp (
        .fill    (count),
        .code    (avail_sel),
        .reached (data_avail)
    );

    rxf_thresh #(.CW(CW)) u_rts_cmp (
        .fill    (count),
        .code    (rts_sel),
        .reached (rts_level_hit)
    );

    assign rts_request = !rts_level_hit;
    assign rts_out     = rts_request ^ rts_active_low;
    assign rd_data     = head_entry.data;
    assign rd_err      = head_entry.err;

    // R4: lowest level is one entry, so an empty buffer never flags data
    p_avail_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !data_avail);

    // R4: highest level fits in the depth, so a full buffer always flags data
    p_avail_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> data_avail);

    // R5 R6: a full buffer withdraws the request at the selected polarity
    p_rts_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (rts_out == rts_active_low));

    // R5 R6: an empty buffer asks for data at the selected polarity
    p_rts_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rts_out != rts_active_low));
endmodule

// File: tb/rx_trig_fifo_test.sv
module rx_trig_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, rd_en = 0, flush = 0, ovf_clr = 0, rts_active_low = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] wr_err = 0;
    logic [1:0] avail_sel = 0, rts_sel = 0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic       empty, full, overflow, data_avail, rts_out;
    logic [4:0] count;

    always #4 clk = ~clk;

    rx_trig_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .flush(flush), .ovf_clr(ovf_clr),
        .avail_sel(avail_sel), .rts_sel(rts_sel), .rts_active_low(rts_active_low),
        .empty(empty), .full(full), .count(count), .overflow(overflow),
        .data_avail(data_avail), .rts_out(rts_out)
    );

    bit [10:0]   mdl_q[$];
    logic [7:0]  exp_rd = 0;
    logic [2:0]  exp_err = 0;
    bit          exp_ovf = 0;
    int unsigned checks = 0, errors = 0;

    function automatic int lvl(logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int sz = mdl_q.size();
        bit req = (sz < lvl(rts_sel));
        bit exp_rts = req ^ rts_active_low;
        chk(count == sz, "R3 count", count, sz);
        chk(empty == (sz == 0), "R3 empty", empty, sz == 0);
        chk(full == (sz == 16), "R3 full", full, sz == 16);
        chk(overflow == exp_ovf, "R7 overflow", overflow, exp_ovf);
        chk(data_avail == (sz >= lvl(avail_sel)), "R4 data_avail", data_avail, sz >= lvl(avail_sel));
        chk(rts_out == exp_rts, "R5 R6 rts_out", rts_out, exp_rts);
        chk(rd_data == exp_rd, "R2 rd_data", rd_data, exp_rd);
        chk(rd_err == exp_err, "R2 rd_err", rd_err, exp_err);
    endtask

    task automatic cycle();
        int  sz;
        bit  drop = 0;
        bit [10:0] v;
        @(posedge clk);
        sz = mdl_q.size();
        if (flush) begin
            mdl_q.delete();
        end else begin
            if (rd_en && sz > 0) begin
                v = mdl_q.pop_front();
                exp_rd = v[7:0];
                exp_err = v[10:8];
            end
            if (wr_en) begin
                if (sz < 16) mdl_q.push_back({wr_err, wr_data});
                else drop = 1;
            end
        end
        if (ovf_clr) exp_ovf = 0;
        if (drop) exp_ovf = 1;
        @(negedge clk);
        compare_all();
    endtask

    task automatic push(logic [7:0] d, logic [2:0] e);
        wr_en = 1; wr_data = d; wr_err = e;
        cycle();
        wr_en = 0;
    endtask

    task automatic pop();
        rd_en = 1;
        cycle();
        rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(empty == 1 && full == 0 && count == 0 && overflow == 0, "R1 status", {empty, full, overflow}, 3'b100);
        chk(rd_data == 0 && rd_err == 0, "R1 read outputs", rd_data, 0);

        // R4 R5 R6: sweep every code at every fill level
        for (int f = 0; f <= 16; f++) begin
            for (int c = 0; c < 4; c++) begin
                avail_sel = 2'(c);
                rts_sel = 2'(3 - c);
                rts_active_low = c[0];
                cycle();
                rts_sel = 2'(c);
                rts_active_low = ~c[0];
                cycle();
            end
            if (f < 16) push(8'(f * 7 + 3), 3'(f));
        end

        // R7: pushes while full are dropped
        push(8'hAA, 3'd5);
        chk(overflow == 1 && count == 16, "R7 drop while full", count, 16);
        push(8'hBB, 3'd6);
        // R8: clear and drop in the same cycle keeps the flag set
        ovf_clr = 1;
        push(8'hCC, 3'd7);
        ovf_clr = 0;
        chk(overflow == 1, "R8 set wins over clear", overflow, 1);
        ovf_clr = 1; cycle(); ovf_clr = 0;
        chk(overflow == 0, "R8 clear", overflow, 0);

        // R2: pop a few in order
        for (int i = 0; i < 4; i++) pop();
        chk(rd_data == 8'(3 * 7 + 3) && rd_err == 3'd3, "R2 order", rd_data, 3 * 7 + 3);

        // R11: simultaneous push and pop
        for (int i = 0; i < 5; i++) begin
            c0 = count;
            wr_en = 1; rd_en = 1; wr_data = 8'(8'h40 + i); wr_err = 3'(i);
            cycle();
            chk(count == c0, "R11 count steady", count, c0);
        end
        wr_en = 0; rd_en = 0;

        // drain, then R9 pops on empty
        while (mdl_q.size() > 0) pop();
        held = rd_data;
        pop();
        pop();
        chk(rd_data == held && count == 0, "R9 pop on empty", rd_data, held);

        // push and pop together on empty: push lands, pop ignored
        wr_en = 1; rd_en = 1; wr_data = 8'h5A; wr_err = 3'd2;
        cycle();
        wr_en = 0; rd_en = 0;
        chk(count == 1 && rd_data == held, "R9 pop ignored on empty", count, 1);

        // R10 flush overrides push and pop
        for (int i = 0; i < 5; i++) push(8'(8'h90 + i), 3'(i + 1));
        held = rd_data;
        flush = 1; wr_en = 1; rd_en = 1; wr_data = 8'hEE;
        cycle();
        flush = 0; wr_en = 0; rd_en = 0;
        chk(count == 0 && empty == 1 && rd_data == held, "R10 flush", count, 0);

        // resume after flush
        for (int i = 0; i < 3; i++) push(8'(8'h20 + i), 3'(i));
        for (int i = 0; i < 3; i++) pop();
        chk(rd_data == 8'h22 && rd_err == 3'd2, "R2 order after flush", rd_data, 8'h22);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule